// File: doc/BRIEF.md
# Programmable Next-State Sequencer

This block is a small state machine whose transition graph lives in a writable lookup table, not in fixed gates. The current state drives the read address of a table that has one entry per possible state. The word read back is loaded into the state register on every rising clock edge, so it becomes the next state. The table read is combinational, which means each transition costs exactly one clock.

A write port lets the surrounding logic rewrite any entry while the machine runs. The same hardware can therefore step through a binary count, a Gray-code cycle, a short loop, or a state that holds on itself. Reset clears the state to zero and loads the table with the increment pattern, so the block counts up as soon as reset ends.

Reset takes effect at once, without a clock edge. It is released in step with the clock through a two-stage synchronizer.

Top module: `table_sequencer`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0. It becomes 0 as soon as `rst_ni` falls, without waiting for a clock edge.
- R2: Reset loads entry n of the table with (n+1) mod 16. With no writes after reset, the state steps 0, 1, 2, ... 15 and then wraps to 0.
- R3: After `rst_ni` rises, `state_o` stays at 0 through the next two rising clock edges. It first advances on the third rising edge.
- R4: Once out of reset, each rising clock edge loads `state_o` with the table entry addressed by the previous `state_o`. Between edges the state does not change.
- R5: When `wr_en_i` is 1 at a rising edge, the entry at address `wr_addr_i` takes the value `wr_data_i`. The next visit to that state follows the new entry.
- R6: When `wr_en_i` is 0, `wr_addr_i` and `wr_data_i` have no effect on the table or on the state sequence.
- R7: A write to the entry addressed by the current state, in the same cycle, does not affect the transition taken at that edge: the register loads the old entry. Later visits to that state use the new entry.
- R8: An entry that holds its own address makes the state stay there on every following edge until that entry is rewritten.
- R9: Any programmed sequence, including a 16-state Gray-code cycle, is followed transition by transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state and table change on its rising edge |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 4 | Table entry to write |
| wr_data_i | input | 4 | Next-state value to store |
| state_o | output | 4 | Current state; this is also the table read address |

## Verification
The bench builds the block with its default state width of four bits, so the table has 16 entries. With that width, every state and every table entry can be reached within a few dozen cycles. The bench covers the full wrap from the top state to zero, rewrites of the whole table into a Gray cycle, and a write that collides with the entry being read. A reference model computes every transition, so any entry the design misreads or any write it drops shows up at the next visit to that state.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  // Value held by a table entry after reset: the increment successor.
  function automatic int unsigned reset_successor(int unsigned idx, int unsigned depth);
    return (idx + 1) % depth;
  endfunction
endpackage

// File: rtl/seq_rst_sync.sv
`timescale 1ns/1ps
module seq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/seq_next_table.sv
`timescale 1ns/1ps
module seq_next_table #(
  parameter int unsigned STATE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [STATE_W-1:0]         wr_addr_i,
  input  logic [STATE_W-1:0]         wr_data_i,
  input  logic [STATE_W-1:0]         rd_addr_i,
  output logic [STATE_W-1:0]         rd_data_o,
  output logic [(2**STATE_W)*STATE_W-1:0] tbl_o
);
  localparam int unsigned DEPTH = 2 ** STATE_W;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam logic [STATE_W-1:0] INIT =
      STATE_W'(seq_pkg::reset_successor(e, DEPTH));
    logic               sel;
    logic [STATE_W-1:0] entry_d;
    logic [STATE_W-1:0] entry_q;

    always_comb begin
      sel     = wr_en_i && (wr_addr_i == STATE_W'(e));
      entry_d = sel ? wr_data_i : entry_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) entry_q <= INIT;
      else         entry_q <= entry_d;
    end

    assign tbl_o[e*STATE_W +: STATE_W] = entry_q;
  end

  always_comb begin
    rd_data_o = tbl_o[rd_addr_i*STATE_W +: STATE_W];
  end
endmodule

// File: rtl/seq_state_reg.sv
`timescale 1ns/1ps
module seq_state_reg #(
  parameter int unsigned STATE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] state_d;
  logic [STATE_W-1:0] state_q;

  always_comb begin
    state_d = next_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/table_sequencer.sv
`timescale 1ns/1ps
module table_sequencer #(
  parameter int unsigned STATE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [STATE_W-1:0] wr_addr_i,
  input  logic [STATE_W-1:0] wr_data_i,
  output logic [STATE_W-1:0] state_o
);
  localparam int unsigned DEPTH = 2 ** STATE_W;

  logic                       rst_sync_n;
  logic [STATE_W-1:0]         cur_state;
  logic [STATE_W-1:0]         rd_data;
  logic [DEPTH*STATE_W-1:0]   tbl_flat;

  seq_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  seq_next_table #(.STATE_W(STATE_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (cur_state),
    .rd_data_o (rd_data),
    .tbl_o     (tbl_flat)
  );

  seq_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .next_i  (rd_data),
    .state_o (cur_state)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/table_sequencer_chk.sv
`timescale 1ns/1ps
module table_sequencer_chk #(
  parameter int unsigned STATE_W = 4
) (
  input logic                            clk_i,
  input logic                            rst_n,
  input logic [STATE_W-1:0]              state,
  input logic [STATE_W-1:0]              rd_data,
  input logic                            wr_en,
  input logic [STATE_W-1:0]              wr_addr,
  input logic [STATE_W-1:0]              wr_data,
  input logic [(2**STATE_W)*STATE_W-1:0] tbl
);
  // R4
  follow_table_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(rst_n) |-> state == $past(rd_data));

  // R5
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |->
      tbl[$past(wr_addr)*STATE_W +: STATE_W] == $past(wr_data));

  // R6
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> $stable(tbl));

  // R3
  first_cycle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(rst_n) |-> state == '0);

  // R8
  self_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && rd_data == state) |=> $stable(state));
endmodule

bind table_sequencer table_sequencer_chk #(.STATE_W(STATE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .state   (cur_state),
  .rd_data (rd_data),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i),
  .tbl     (tbl_flat)
);

// File: tb/tb_table_sequencer.sv
`timescale 1ns/1ps
module tb_table_sequencer;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [3:0] wr_addr_i;
  logic [3:0] wr_data_i;
  logic [3:0] state_o;

  int total = 0;
  int bad   = 0;

  logic [3:0] model_tbl [16];
  logic [3:0] model_st;

  table_sequencer dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .state_o   (state_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check mid-cycle and after the edge.
  task automatic tick(input string req, input logic en, input logic [3:0] a, input logic [3:0] d);
    logic [3:0] nxt;
    @(negedge clk_i);
    chk("R4 stable between edges", state_o, model_st);
    wr_en_i = en; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    nxt = model_tbl[model_st];
    if (en) model_tbl[a] = d;
    model_st = nxt;
    #1;
    chk(req, state_o, model_st);
  endtask

  task automatic do_reset();
    @(posedge clk_i);
    #2 rst_ni = 1'b0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    #1 chk("R1 async clear", state_o, 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 16; i++) model_tbl[i] = 4'((i + 1) % 16);
    model_st = 4'h0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_i); #1;
      chk("R3 held after release", state_o, 4'h0);
    end
  endtask

  task automatic test_count();
    do_reset();
    for (int i = 0; i < 20; i++) tick("R2 count and wrap", 1'b0, 4'h0, 4'h0);
    chk("R2 wrapped value", state_o, 4'h4);
  endtask

  task automatic test_ignored_write();
    do_reset();
    for (int i = 0; i < 18; i++)
      tick("R6 disabled write ignored", 1'b0, 4'(i), 4'(15 - i));
  endtask

  task automatic test_gray();
    logic [3:0] g [16];
    do_reset();
    for (int i = 0; i < 16; i++) g[i] = 4'(i ^ (i >> 1));
    for (int i = 0; i < 16; i++) tick("R5 write while running", 1'b1, g[i], g[(i + 1) % 16]);
    for (int i = 0; i < 34; i++) tick("R9 gray sequence", 1'b0, 4'h0, 4'h0);
  endtask

  task automatic test_collide();
    logic [3:0] here;
    do_reset();
    for (int i = 0; i < 3; i++) tick("R4 advance", 1'b0, 4'h0, 4'h0);
    here = model_st;
    tick("R7 old entry used", 1'b1, here, 4'hA);
    chk("R7 next is old successor", state_o, 4'(here + 1));
    for (int i = 0; i < 18; i++) tick("R7 new entry on revisit", 1'b0, 4'h0, 4'h0);
  endtask

  task automatic test_self_loop();
    do_reset();
    tick("R5 program loop", 1'b1, 4'h5, 4'h5);
    while (model_st != 4'h5) tick("R4 approach", 1'b0, 4'h0, 4'h0);
    for (int i = 0; i < 6; i++) tick("R8 self loop hold", 1'b0, 4'h0, 4'h0);
    chk("R8 still parked", state_o, 4'h5);
    tick("R8 release loop", 1'b1, 4'h5, 4'h9);
    for (int i = 0; i < 3; i++) tick("R8 leaves after rewrite", 1'b0, 4'h0, 4'h0);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    #20;
    chk("R1 reset state", state_o, 4'h0);
    test_count();
    test_ignored_write();
    test_gray();
    test_collide();
    test_self_loop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule